// File: doc/BRIEF.md
# Write-Once Output Disable Controller

This block holds the protection setup for a set of timer output pin groups and works out, each cycle, which groups must be forced to high impedance. A 16-bit control word holds twelve pin-group enables. The word has four reserved positions. A second, one-bit word holds the enable for a single standalone pin. Each enable bit takes its value from the first write after power-on reset. Later writes to that bit are ignored, so software cannot loosen the protection once it has set it up.

Each enabled pin group goes to high impedance in two cases. The first is when any of its four fault flags or its software request is high. The second is when its comparison-fault flag is high while the compare enable for that group is set. A disabled group is never forced off and is not armed for level comparison. The standalone pin goes to high impedance when it is enabled and either its fault flag or its software request is high. All high-Z outputs are combinational from the stored enables and the live flags.

Top module: `odc_top`

## Requirements
- R1: After reset the control word (addr 0) reads 0x7700 and the single-pin word (addr 1) reads 0x0000.
- R2: Control-word bits 15, 11, 7 and 3 always read 0, and writing 1 to them has no effect.
- R3: The first write to a word after reset stores the written data into every non-reserved bit of that word. The new value is readable right after the write clock edge.
- R4: Once a bit has been written, every later write to it is ignored until the next reset. A write of the bit's current value still uses up its one allowed write.
- R5: The control word and the single-pin word lock independently. A write to one does not lock or change the other.
- R6: Group g is controlled by control-word bit g + g/3, using integer division (groups 0..11 map to bits 0,1,2,4,5,6,8,9,10,12,13,14). `grpCmpArm[g]` equals that bit.
- R7: An enabled group drives `grpHiZ[g]` high when any of its four `grpFault` flags (bits 4g..4g+3) or `grpSwReq[g]` is high.
- R8: An enabled group drives `grpHiZ[g]` high when `grpCmpFault[g]` and `grpCmpEn[g]` are both high. `grpCmpFault[g]` alone has no effect.
- R9: A group whose enable is 0 never drives `grpHiZ[g]` or `grpCmpArm[g]` high, whatever its flags are.
- R10: `pinHiZ` is high exactly when the single-pin enable is 1 and `pinFault` or `pinSwReq` is high.
- R11: High-Z outputs follow flag changes in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| wrEn | input | 1 | Write strobe for the whole 16-bit word |
| addr | input | 1 | 0 selects the control word, 1 selects the single-pin word |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the selected word |
| grpFault | input | 48 | Four fault flags per group, group g at bits 4g..4g+3 |
| grpSwReq | input | 12 | Software high-Z request per group |
| grpCmpFault | input | 12 | Comparison-fault flag per group |
| grpCmpEn | input | 12 | Compare enable per group |
| grpHiZ | output | 12 | High-Z enable per group |
| grpCmpArm | output | 12 | Group is armed for level comparison |
| pinFault | input | 1 | Fault flag for the single pin |
| pinSwReq | input | 1 | Software high-Z request for the single pin |
| pinHiZ | output | 1 | High-Z enable for the single pin |

## Verification
Stored bits change at the clock edge of the write and can be read 1 ns after that edge. The bench therefore performs each write on one edge and reads the word straight after it, before the next edge. The high-Z and arm outputs have no register between them and the flags. Flag changes are applied between edges and checked 1 ns later with no edge in between. This also shows that nothing waits for a clock.

// File: rtl/odc_pkg.sv
package odc_pkg;
  localparam int REG_W     = 16;
  localparam int NUM_GRP   = 12;
  localparam int GRP_SPAN  = 3;
  localparam int FLT_N     = 4;

  typedef struct packed {
    logic wrMain;
    logic wrSingle;
  } odcStrobe_t;
endpackage

// File: rtl/odc_ctrl.sv
module odc_ctrl
  import odc_pkg::*;
(
  input  logic       wrEn,
  input  logic       addr,
  output odcStrobe_t strb
);
  always_comb begin
    strb          = '0;
    strb.wrMain   = wrEn && !addr;
    strb.wrSingle = wrEn && addr;
  end
endmodule

// File: rtl/odc_regs.sv
module odc_regs
  import odc_pkg::*;
#(
  parameter int              W       = REG_W,
  parameter int              NG      = NUM_GRP,
  parameter int              SPAN    = GRP_SPAN,
  parameter logic [W-1:0]    RST_VAL = 16'h7700
) (
  input  logic         clk,
  input  logic         rstN,
  input  odcStrobe_t   strb,
  input  logic         addr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic [NG-1:0] grpEn,
  output logic         pinEn
);
  function automatic logic [W-1:0] mkLive();
    logic [W-1:0] m;
    m = '0;
    for (int g = 0; g < NG; g++) m[g + g / SPAN] = 1'b1;
    return m;
  endfunction

  localparam logic [W-1:0] LIVE = mkLive();

  logic [W-1:0] storedQ;
  logic [W-1:0] writtenQ;
  logic         pinWrittenQ;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (LIVE[b]) begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          storedQ[b]  <= RST_VAL[b];
          writtenQ[b] <= 1'b0;
        end else if (strb.wrMain && !writtenQ[b]) begin
          storedQ[b]  <= wrData[b];
          writtenQ[b] <= 1'b1;
        end
      end
    end else begin : g_rsvd
      assign storedQ[b]  = 1'b0;
      assign writtenQ[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinEn       <= 1'b0;
      pinWrittenQ <= 1'b0;
    end else if (strb.wrSingle && !pinWrittenQ) begin
      pinEn       <= wrData[0];
      pinWrittenQ <= 1'b1;
    end
  end

  assign rdData = addr ? {{(W-1){1'b0}}, pinEn} : storedQ;

  for (genvar g = 0; g < NG; g++) begin : g_map
    assign grpEn[g] = storedQ[g + g / SPAN];
  end

  // R2: reserved positions never read back as 1
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !addr |-> ((rdData & ~LIVE) == '0));

  // R4: bits already written keep their value
  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((storedQ & $past(writtenQ)) == ($past(storedQ) & $past(writtenQ))));

  // R4: single-pin bit holds once written
  p_pin_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    pinWrittenQ |=> $stable(pinEn));

  // R4: written flags never drop outside reset
  p_written_mono_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(writtenQ) & ~writtenQ) == '0));

  // R5: a single-pin write leaves the control word untouched
  p_indep_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSingle |=> $stable(storedQ));
endmodule

// File: rtl/odc_hiz.sv
module odc_hiz
  import odc_pkg::*;
#(
  parameter int NG = NUM_GRP,
  parameter int FN = FLT_N
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NG-1:0]  grpEn,
  input  logic [NG*FN-1:0] grpFault,
  input  logic [NG-1:0]  grpSwReq,
  input  logic [NG-1:0]  grpCmpFault,
  input  logic [NG-1:0]  grpCmpEn,
  input  logic           pinEn,
  input  logic           pinFault,
  input  logic           pinSwReq,
  output logic [NG-1:0]  grpHiZ,
  output logic [NG-1:0]  grpCmpArm,
  output logic           pinHiZ
);
  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic anyFault;
    logic cmpTrip;
    assign anyFault     = (|grpFault[g*FN +: FN]) || grpSwReq[g];
    assign cmpTrip      = grpCmpFault[g] && grpCmpEn[g];
    assign grpHiZ[g]    = grpEn[g] && (anyFault || cmpTrip);
    assign grpCmpArm[g] = grpEn[g];

    // R9: disabled group stays driven
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
      !grpEn[g] |-> (!grpHiZ[g] && !grpCmpArm[g]));

    // R7: enabled group with a raised fault flag is forced off
    p_fault_hiz_r7: assert property (@(posedge clk) disable iff (!rstN)
      (grpEn[g] && (|grpFault[g*FN +: FN])) |-> grpHiZ[g]);

    // R8: ungated compare fault alone does nothing
    p_cmp_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
      (!grpCmpEn[g] && !grpSwReq[g] && !(|grpFault[g*FN +: FN])) |-> !grpHiZ[g]);
  end

  assign pinHiZ = pinEn && (pinFault || pinSwReq);

  // R10: single pin forced off on its own fault when enabled
  p_pin_hiz_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pinEn && pinFault) |-> pinHiZ);
endmodule

// File: rtl/odc_top.sv
module odc_top
  import odc_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int NG = NUM_GRP,
  parameter int FN = FLT_N
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             addr,
  input  logic [W-1:0]     wrData,
  output logic [W-1:0]     rdData,
  input  logic [NG*FN-1:0] grpFault,
  input  logic [NG-1:0]    grpSwReq,
  input  logic [NG-1:0]    grpCmpFault,
  input  logic [NG-1:0]    grpCmpEn,
  output logic [NG-1:0]    grpHiZ,
  output logic [NG-1:0]    grpCmpArm,
  input  logic             pinFault,
  input  logic             pinSwReq,
  output logic             pinHiZ
);
  odcStrobe_t      strb;
  logic [NG-1:0]   grpEn;
  logic            pinEn;

  odc_ctrl u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  odc_regs #(.W(W), .NG(NG)) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .grpEn  (grpEn),
    .pinEn  (pinEn)
  );

  odc_hiz #(.NG(NG), .FN(FN)) u_hiz (
    .clk         (clk),
    .rstN        (rstN),
    .grpEn       (grpEn),
    .grpFault    (grpFault),
    .grpSwReq    (grpSwReq),
    .grpCmpFault (grpCmpFault),
    .grpCmpEn    (grpCmpEn),
    .pinEn       (pinEn),
    .pinFault    (pinFault),
    .pinSwReq    (pinSwReq),
    .grpHiZ      (grpHiZ),
    .grpCmpArm   (grpCmpArm),
    .pinHiZ      (pinHiZ)
  );
endmodule

// File: tb/sim_odc_top.sv
module sim_odc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [47:0] grpFault = '0;
  logic [11:0] grpSwReq = '0;
  logic [11:0] grpCmpFault = '0;
  logic [11:0] grpCmpEn = '0;
  logic [11:0] grpHiZ;
  logic [11:0] grpCmpArm;
  logic        pinFault = 1'b0;
  logic        pinSwReq = 1'b0;
  logic        pinHiZ;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  odc_top u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] enOf(input logic [15:0] w);
    logic [11:0] e;
    for (int g = 0; g < 12; g++) e[g] = w[g + g / 3];
    return e;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0;
    grpFault = '0; grpSwReq = '0; grpCmpFault = '0; grpCmpEn = '0;
    pinFault = 1'b0; pinSwReq = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    addr = 1'b0; #1;
    chk("R1 ctrl reset", {16'h0, rdData}, 32'h7700);
    addr = 1'b1; #1;
    chk("R1 single reset", {16'h0, rdData}, 32'h0);
    grpSwReq = '1; pinSwReq = 1'b1; #1;
    chk("R6 reset groups", {20'h0, grpHiZ}, {20'h0, enOf(16'h7700)});
    chk("R10 pin off at reset", {31'h0, pinHiZ}, 32'h0);
    grpSwReq = '0; pinSwReq = 1'b0;
  endtask

  task automatic testFirstAndLock();
    doReset();
    wr(1'b0, 16'hFFFF);
    addr = 1'b0; #1;
    chk("R3/R2 first write", {16'h0, rdData}, 32'h7777);
    wr(1'b0, 16'h0000);
    addr = 1'b0; #1;
    chk("R4 second write ignored", {16'h0, rdData}, 32'h7777);
    chk("R6 arm all", {20'h0, grpCmpArm}, 32'hFFF);
  endtask

  task automatic testSameValue();
    doReset();
    wr(1'b0, 16'h7700);
    wr(1'b0, 16'h0077);
    addr = 1'b0; #1;
    chk("R4 same-value write locks", {16'h0, rdData}, 32'h7700);
  endtask

  task automatic testGroups();
    logic [15:0] w;
    logic [11:0] en;
    w = 16'h0536;
    doReset();
    wr(1'b0, w);
    en = enOf(w);
    chk("R6 arm map", {20'h0, grpCmpArm}, {20'h0, en});
    for (int g = 0; g < 12; g++) begin
      for (int f = 0; f < 4; f++) begin
        grpFault = '0; grpFault[g*4+f] = 1'b1; #1;
        chk("R7 fault flag", {20'h0, grpHiZ}, {20'h0, en & (12'h1 << g)});
      end
      grpFault = '0; grpSwReq = 12'h1 << g; #1;
      chk("R7 sw request", {20'h0, grpHiZ}, {20'h0, en & (12'h1 << g)});
      grpSwReq = '0;
    end
    grpCmpFault = '1; grpCmpEn = '0; #1;
    chk("R8 ungated compare", {20'h0, grpHiZ}, 32'h0);
    grpCmpEn = 12'hA5A; #1;
    chk("R8 gated compare", {20'h0, grpHiZ}, {20'h0, en & 12'hA5A});
    grpCmpFault = '0; grpCmpEn = '0;
    grpFault = '1; grpSwReq = '1; grpCmpFault = '1; grpCmpEn = '1; #1;
    chk("R9 disabled stay low", {20'h0, grpHiZ & ~en}, 32'h0);
    grpFault = '0; grpSwReq = '0; grpCmpFault = '0; grpCmpEn = '0;
  endtask

  task automatic testComb();
    doReset();
    @(posedge clk); #2;
    grpFault[44] = 1'b1; #1;
    chk("R11 same-cycle rise", {20'h0, grpHiZ}, 32'h800);
    grpFault[44] = 1'b0; #1;
    chk("R11 same-cycle fall", {20'h0, grpHiZ}, 32'h0);
  endtask

  task automatic testSingle();
    doReset();
    wr(1'b1, 16'hFFFF);
    addr = 1'b1; #1;
    chk("R3 single first write", {16'h0, rdData}, 32'h1);
    wr(1'b1, 16'h0000);
    addr = 1'b1; #1;
    chk("R4 single locked", {16'h0, rdData}, 32'h1);
    addr = 1'b0; #1;
    chk("R5 ctrl untouched", {16'h0, rdData}, 32'h7700);
    wr(1'b0, 16'h0001);
    addr = 1'b0; #1;
    chk("R5 ctrl still writable", {16'h0, rdData}, 32'h0001);
    addr = 1'b1; #1;
    chk("R5 single kept", {16'h0, rdData}, 32'h1);
    pinFault = 1'b1; #1;
    chk("R10 pin fault", {31'h0, pinHiZ}, 32'h1);
    pinFault = 1'b0; pinSwReq = 1'b1; #1;
    chk("R10 pin sw", {31'h0, pinHiZ}, 32'h1);
    pinSwReq = 1'b0; #1;
    chk("R10 pin idle", {31'h0, pinHiZ}, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testFirstAndLock();
    testSameValue();
    testGroups();
    testComb();
    testSingle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule